// File: doc/BRIEF.md
# Hierarchical Column-Method 8x8 Multiplier

This block multiplies two unsigned 8-bit operands and registers the 16-bit product. Each operand is cut into a 4-bit upper half and a 4-bit lower half. Four identical 4x4 sub-multipliers form the four half-by-half products. Three ripple-carry adders then shift and sum them: the upper-by-upper product at weight 2^8, the two mixed products at weight 2^4, and the lower-by-lower product at weight 2^0.

Each 4x4 sub-multiplier works column by column in the vertical-and-crosswise manner. Every column collects the bit products whose index pair adds up to that column's weight. A 4:2 compressor reduces that column. It is made of two full adders in series. The first adder's carry moves sideways into the compressor of the next column, and the second adder takes the sideways carry from the column below. A final ripple addition merges the column sums with the column carries.

A caller drives both operands with an input-valid strobe. One clock later the product appears together with the output-valid strobe.

Top module: `vcx_mul8`

## Requirements
- R1: One clock edge after an edge that samples `in_valid` high, `prod` equals the unsigned product `op_a * op_b` of the operands sampled at that edge, for every one of the 65,536 operand pairs.
- R2: `out_valid` equals the value that `in_valid` had at the previous clock edge, so the latency is exactly one cycle.
- R3: At an edge where `in_valid` is low, `prod` keeps its previous value whatever `op_a` and `op_b` carry.
- R4: At an edge where `rst` is high, `prod` becomes 0 and `out_valid` becomes 0. This holds even if `in_valid` is high at that edge.
- R5: The product is assembled as upper*upper*256 + (upper*lower + lower*upper)*16 + lower*lower, where upper is bits [7:4] and lower is bits [3:0] of each operand. When one operand is 0, or when only one half of each operand is nonzero, the result equals the single matching term.
- R6: The sum of the two mixed terms keeps its ninth bit. With both operands at 255, the mixed sum is 450 and the result is 65025.
- R7: Columns that hold the full four bit products are reduced without loss. With both lower halves at 15 and both upper halves at 0, the result is 225.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid; the product register loads |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Registered unsigned product |
| out_valid | output | 1 | Product register was loaded at the last edge |

## Verification
The assertions assume that `op_a`, `op_b` and `in_valid` are stable and free of X around each rising edge. They also assume that `rst` is high at the first edge, so the one-cycle look-back never reaches a cycle before reset. The bench drives every input only on falling edges. It holds `rst` high from time zero through the first edges, and it keeps every operand a defined 8-bit value, including in the cycles where `in_valid` is low.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  // number of same-weight inputs a compressor cell accepts
  localparam int unsigned CMP_IN = 4;
endpackage

// File: rtl/vcx_fa.sv
module vcx_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ z;
  assign co = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/vcx_cmp42.sv
// Two chained full adders. cout is a function of x1..x3 only, so the
// sideways carry chain never ripples through neighbouring cells.
module vcx_cmp42 (
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic x4,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout
);
  logic s_first;

  vcx_fa u_fa_a (.x(x1), .y(x2), .z(x3), .s(s_first), .co(cout));
  vcx_fa u_fa_b (.x(s_first), .y(x4), .z(cin), .s(sum), .co(carry));
endmodule

// File: rtl/vcx_rca.sv
module vcx_rca #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] c;

  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_bit
    vcx_fa u_fa (.x(a[i]), .y(b[i]), .z(c[i]), .s(s[i]), .co(c[i+1]));
  end
  assign cout = c[W];
endmodule

// File: rtl/vcx_submul.sv
// Column-method N x N multiplier: one 4:2 compressor per column, a lateral
// carry between neighbouring columns, then one carry-propagate merge.
// N must not exceed the compressor width (each column holds at most N products).
module vcx_submul
  import vcx_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int unsigned NCOL = 2 * N;

  logic [NCOL-1:0] col_sum;
  logic [NCOL-1:0] col_carry;
  logic [NCOL:0]   lat;

  assign lat[0] = 1'b0;

  for (genvar k = 0; k < NCOL; k++) begin : g_col
    logic [CMP_IN-1:0] pp;

    always_comb begin
      int unsigned n;
      pp = '0;
      n  = 0;
      for (int unsigned i = 0; i < N; i++) begin
        for (int unsigned j = 0; j < N; j++) begin
          if (i + j == k) begin
            pp[n[1:0]] = a[i] & b[j];
            n = n + 1;
          end
        end
      end
    end

    vcx_cmp42 u_cmp (
      .x1(pp[0]), .x2(pp[1]), .x3(pp[2]), .x4(pp[3]),
      .cin(lat[k]),
      .sum(col_sum[k]), .carry(col_carry[k]), .cout(lat[k+1])
    );
  end

  logic merge_unused_co;
  logic unused_top_bits;

  vcx_rca #(.W(NCOL)) u_merge (
    .a(col_sum),
    .b({col_carry[NCOL-2:0], 1'b0}),
    .cin(1'b0),
    .s(p),
    .cout(merge_unused_co)
  );

  // the top column's outgoing carries carry weight 2^(2N) and are always zero
  assign unused_top_bits = col_carry[NCOL-1] ^ lat[NCOL] ^ merge_unused_co;
endmodule

// File: rtl/vcx_mul8.sv
module vcx_mul8 #(
  parameter int unsigned OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [2*OP_W-1:0] prod,
  output logic              out_valid
);
  localparam int unsigned HW = OP_W / 2;
  localparam int unsigned PW = 2 * OP_W;

  logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [2*HW-1:0] p_hh, p_hl, p_lh, p_ll;

  assign a_hi = op_a[OP_W-1:HW];
  assign a_lo = op_a[HW-1:0];
  assign b_hi = op_b[OP_W-1:HW];
  assign b_lo = op_b[HW-1:0];

  vcx_submul #(.N(HW)) u_hh (.a(a_hi), .b(b_hi), .p(p_hh));
  vcx_submul #(.N(HW)) u_hl (.a(a_hi), .b(b_lo), .p(p_hl));
  vcx_submul #(.N(HW)) u_lh (.a(a_lo), .b(b_hi), .p(p_lh));
  vcx_submul #(.N(HW)) u_ll (.a(a_lo), .b(b_lo), .p(p_ll));

  // middle term keeps its carry-out
  logic [2*HW-1:0] mid_s;
  logic            mid_co;

  vcx_rca #(.W(2*HW)) u_add_mid (
    .a(p_hl), .b(p_lh), .cin(1'b0), .s(mid_s), .cout(mid_co)
  );

  logic [PW-1:0] low_part, mid_part, hi_part, t_sum, p_comb;
  logic          unused_co_t, unused_co_p;

  assign low_part = {{(PW-2*HW){1'b0}}, p_ll};
  assign mid_part = {{(PW-3*HW-1){1'b0}}, mid_co, mid_s, {HW{1'b0}}};
  assign hi_part  = {p_hh, {(PW-2*HW){1'b0}}};

  vcx_rca #(.W(PW)) u_add_lo (
    .a(low_part), .b(mid_part), .cin(1'b0), .s(t_sum), .cout(unused_co_t)
  );
  vcx_rca #(.W(PW)) u_add_hi (
    .a(t_sum), .b(hi_part), .cin(1'b0), .s(p_comb), .cout(unused_co_p)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) prod <= p_comb;
    end
  end
endmodule

// File: rtl/vcx_mul8_chk.sv
module vcx_mul8_chk #(
  parameter int unsigned OP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic [2*OP_W-1:0] prod,
  input logic              out_valid
);
  localparam int unsigned PW = 2 * OP_W;

  p_product_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> prod == (PW'($past(op_a)) * PW'($past(op_b))));

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_low_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prod));

  p_reset_clear_r4: assert property (@(posedge clk)
    rst |=> (prod == '0) && !out_valid);
endmodule

bind vcx_mul8 vcx_mul8_chk #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .prod(prod), .out_valid(out_valid)
);

// File: tb/vcx_mul8_tb.sv
module vcx_mul8_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [15:0] prod;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vcx_mul8 #(.OP_W(8)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .prod(prod), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one valid pair, check on the next falling edge
  task automatic one_pair(input string req, input logic [7:0] a, input logic [7:0] b, input logic [15:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, prod, exp);
    check({req, " valid"}, {15'd0, out_valid}, 16'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R4 prod after reset", prod, 16'd0);
    check("R4 out_valid after reset", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_exhaustive_r1();
    logic [15:0] exp_q;
    @(negedge clk);
    for (int i = 0; i < 65536; i++) begin
      op_a = i[15:8]; op_b = i[7:0]; in_valid = 1'b1;
      exp_q = 16'(i[15:8]) * 16'(i[7:0]);
      @(negedge clk);
      check("R1 exhaustive", prod, exp_q);
      check("R2 valid latency", {15'd0, out_valid}, 16'd1);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_hold_r3();
    one_pair("R3 setup", 8'd13, 8'd11, 16'd143);
    for (int k = 0; k < 3; k++) begin
      op_a = 8'(8'hA5 + k); op_b = 8'(8'h3C + k); in_valid = 1'b0;
      @(negedge clk);
      check("R3 hold", prod, 16'd143);
      check("R2 no valid", {15'd0, out_valid}, 16'd0);
    end
  endtask

  task automatic t_corners();
    one_pair("R5 zero operand", 8'd0, 8'd200, 16'd0);
    one_pair("R5 upper only", 8'h30, 8'h50, 16'd3840);
    one_pair("R5 lower only", 8'h07, 8'h09, 16'd63);
    one_pair("R5 cross only", 8'h20, 8'h03, 16'd96);
    one_pair("R6 mid carry", 8'hFF, 8'hFF, 16'd65025);
    one_pair("R6 mid carry 2", 8'hF8, 8'h8F, 16'd35464);
    one_pair("R7 full columns", 8'h0F, 8'h0F, 16'd225);
  endtask

  task automatic t_reset_mid_r4();
    one_pair("R4 setup", 8'd99, 8'd77, 16'd7623);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; op_a = 8'd5; op_b = 8'd6;
    @(negedge clk);
    check("R4 reset wins over valid", prod, 16'd0);
    check("R4 valid cleared", {15'd0, out_valid}, 16'd0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    rst = 1'b0;
    t_corners();
    t_hold_r3();
    t_reset_mid_r4();
    t_exhaustive_r1();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule